// File: doc/BRIEF.md
# Boot Record Fetch Sequencer

This block is the bus master that runs right after reset. It reads a boot record from a fixed 48-byte window at the top of the address space. When the self-test strap is set, an internal self-test phase runs first and the bus stays quiet during it. The active-low fail pin then gives one short high pulse. After the pulse the block reads a four-byte region configuration word, one byte per access and in an interleaved order. It then reads eight 32-bit words, and each word is split into byte, half-word or word accesses to match the boot region width that the strap selects.

The eight words are added together as a 32-bit wrap-around sum. A sum of zero means the record is good. In that case the fail pin goes high and stays high, and the start instruction pointer (word 0) and the control-block pointer (word 1) are held for the later boot stages. Any other sum stops the block in an error state with the fail pin low. The assembled configuration word applies to the top 256 MiB region only while the boot runs. A later stage replaces it.

The states are SELFTEST, PULSE, CFG, WORDS, CHECK, PASS and FAIL. The transitions are:
- SELFTEST→PULSE when self-test is disabled, or when its cycle count is used up.
- PULSE→CFG after the pulse length.
- CFG→WORDS on the acknowledge of the fourth configuration byte.
- WORDS→CHECK on the last beat of the last word.
- CHECK→PASS when the sum is zero, otherwise CHECK→FAIL.

PASS and FAIL are terminal until the next reset.

Top module: `boot_rec_fetch`

## Requirements
- R1: `selftest_strap` and `width_strap` are captured on every clock while `rst_n` is low. Width code 00 selects 8-bit, 01 selects 16-bit, and 10 or 11 select 32-bit.
- R2: With the self-test strap set, the block stays in self-test for SELFTEST_CYCLES cycles. Without it, the block spends a single decision cycle there. `rd_req` stays low throughout.
- R3: `fail_n` is low in reset and during self-test. It is then high for exactly PULSE_CYCLES cycles, and it is low on every cycle in which a read is outstanding.
- R4: The configuration bytes are read as byte accesses (`rd_size` 00) at window offsets 0x00, 0x08, 0x04 and 0x0C, in that order. Offset 4·k holds byte k of `region_cfg`, and the byte arrives in `rd_data[7:0]`. `region_cfg_vld` goes high once the fourth byte has been taken.
- R5: The words are read at window offsets 0x10 to 0x2C. In 8-bit mode each word takes four byte accesses at +0..+3. In 16-bit mode each word takes two half-word accesses (`rd_size` 01) at +0 and +2. In 32-bit mode each word takes one access (`rd_size` 10).
- R6: A narrow beat is taken from the low bits of `rd_data`, and all higher bits are ignored. Beats are placed little-endian by address.
- R7: `rd_burst` is high on every word beat except the last one of its word. It is low for configuration bytes and for 32-bit words.
- R8: Only one read is outstanding at a time. `rd_addr`, `rd_size` and `rd_burst` stay stable while `rd_req` is high without `rd_ack`.
- R9: `start_ip` holds word 0 and `ctrl_ptr` holds word 1.
- R10: When the modulo-2^32 sum of the eight words is zero, `boot_ok` and `fail_n` go high and stay high. Otherwise `boot_err` goes high and `fail_n` stays low. After either outcome, no further reads are issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the straps are sampled while it is low |
| selftest_strap | input | 1 | Enables the self-test phase |
| width_strap | input | 2 | Boot region width code |
| rd_req | output | 1 | Read request / address strobe |
| rd_addr | output | ADDR_W | Byte address of the current beat |
| rd_size | output | 2 | Beat size: 00 byte, 01 half-word, 10 word |
| rd_burst | output | 1 | More beats of the same word follow |
| rd_ack | input | 1 | Read data is valid; the beat completes |
| rd_data | input | DATA_W | Read data, right-justified for narrow beats |
| fail_n | output | 1 | Active-low fail indication |
| region_cfg | output | DATA_W | Assembled configuration word for the top region |
| region_cfg_vld | output | 1 | `region_cfg` is complete |
| start_ip | output | DATA_W | Start instruction pointer (word 0) |
| ctrl_ptr | output | DATA_W | Control-block pointer (word 1) |
| boot_ok | output | 1 | The checksum passed |
| boot_err | output | 1 | The checksum failed |

## Verification
The assertions check these properties on every cycle:
- a held request keeps its address and size until it is acknowledged;
- each address stays inside the 48-byte window;
- configuration beats are unburst bytes;
- half-word beats are even-aligned;
- a read never overlaps a high fail pin;
- the PASS outcome is sticky and the bus stays silent after either outcome.

Some behaviour can only be shown by the bench scenarios: the exact 0/2/1/3 byte order, the per-width beat addresses, the little-endian assembly with junk in the unused data bits, the lengths of the self-test and pulse phases, and the pass or fail result for a given record.

// File: rtl/bf_pkg.sv
package bf_pkg;

    typedef enum logic [2:0] {
        ST_SELFTEST,
        ST_PULSE,
        ST_CFG,
        ST_WORDS,
        ST_CHECK,
        ST_PASS,
        ST_FAIL
    } bf_state_e;

    // beat size codes as they appear on rd_size
    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_HALF = 2'b01;
    localparam logic [1:0] SZ_WORD = 2'b10;

    // boot width strap codes
    localparam logic [1:0] BW_8  = 2'b00;
    localparam logic [1:0] BW_16 = 2'b01;

endpackage

// File: rtl/bf_lane_plan.sv
module bf_lane_plan
    import bf_pkg::*;
#(
    parameter int LANE_W = 2
) (
    input  logic [1:0]        width_code,
    input  logic [LANE_W-1:0] beat_idx,
    output logic [1:0]        beat_size,
    output logic [LANE_W-1:0] beats_last,
    output logic [LANE_W-1:0] lane
);

    always_comb begin
        unique case (width_code)
            BW_8: begin
                beat_size  = SZ_BYTE;
                beats_last = '1;
                lane       = beat_idx;
            end
            BW_16: begin
                beat_size  = SZ_HALF;
                beats_last = LANE_W'(1);
                lane       = {beat_idx[LANE_W-2:0], 1'b0};
            end
            default: begin
                beat_size  = SZ_WORD;
                beats_last = '0;
                lane       = '0;
            end
        endcase
    end

endmodule

// File: rtl/bf_word_asm.sv
module bf_word_asm
    import bf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic [1:0]        size,
    input  logic [LANE_W-1:0] lane,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] acc,
    output logic [DATA_W-1:0] merged
);

    logic [DATA_W-1:0] keep_mask;
    logic [DATA_W-1:0] place_mask;
    logic [DATA_W-1:0] placed;

    always_comb begin
        unique case (size)
            SZ_BYTE: keep_mask = DATA_W'(8'hFF);
            SZ_HALF: keep_mask = DATA_W'(16'hFFFF);
            default: keep_mask = '1;
        endcase
        place_mask = keep_mask << (8 * lane);
        placed     = (din & keep_mask) << (8 * lane);
        merged     = (acc & ~place_mask) | placed;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    acc <= '0;
        else if (clr)  acc <= '0;
        else if (load) acc <= merged;
    end

    // R6: a half-word beat must land on an even lane
    p_half_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && size == SZ_HALF) |-> !lane[0]);

    // R6: a full-word beat always starts at lane zero
    p_word_lane0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && size == SZ_WORD) |-> (lane == '0));

endmodule

// File: rtl/bf_sum_check.sv
module bf_sum_check #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              add,
    input  logic [DATA_W-1:0] word,
    output logic              sum_zero
);

    logic [DATA_W-1:0] sum_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   sum_q <= '0;
        else if (add) sum_q <= sum_q + word;
    end

    assign sum_zero = (sum_q == '0);

endmodule

// File: rtl/boot_rec_fetch.sv
module boot_rec_fetch
    import bf_pkg::*;
#(
    parameter int                ADDR_W          = 32,
    parameter int                DATA_W          = 32,
    parameter int                NUM_WORDS       = 8,
    parameter int                SELFTEST_CYCLES = 16,
    parameter int                PULSE_CYCLES    = 2,
    parameter logic [ADDR_W-1:0] BASE_ADDR       = 32'hFEFF_FF30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              selftest_strap,
    input  logic [1:0]        width_strap,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [1:0]        rd_size,
    output logic              rd_burst,
    input  logic              rd_ack,
    input  logic [DATA_W-1:0] rd_data,
    output logic              fail_n,
    output logic [DATA_W-1:0] region_cfg,
    output logic              region_cfg_vld,
    output logic [DATA_W-1:0] start_ip,
    output logic [DATA_W-1:0] ctrl_ptr,
    output logic              boot_ok,
    output logic              boot_err
);

    localparam int CFG_BYTES = DATA_W / 8;
    localparam int LANE_W    = $clog2(CFG_BYTES);
    localparam int WIDX_W    = $clog2(NUM_WORDS);
    localparam int CNT_MAX   = (SELFTEST_CYCLES > PULSE_CYCLES) ? SELFTEST_CYCLES : PULSE_CYCLES;
    localparam int CNT_W     = $clog2(CNT_MAX) + 1;
    localparam int CFG_SPAN  = CFG_BYTES * CFG_BYTES;
    localparam int WIN_BYTES = CFG_SPAN + NUM_WORDS * CFG_BYTES;

    bf_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [LANE_W-1:0] cfg_idx_q, beat_idx_q, cfg_lane;
    logic [WIDX_W-1:0] word_idx_q;
    logic              st_en_q;
    logic [1:0]        width_q;
    logic [DATA_W-1:0] cfg_q, ip_q, ctrl_q;

    logic [1:0]        beat_size;
    logic [LANE_W-1:0] beats_last, word_lane;
    logic              ack, last_cfg, last_beat, last_word, sum_zero;
    logic              asm_clr, sum_add;
    logic [1:0]        asm_size;
    logic [LANE_W-1:0] asm_lane;
    logic [DATA_W-1:0] asm_acc, asm_merged;

    // configuration bytes are visited in bit-reversed index order
    for (genvar g = 0; g < LANE_W; g++) begin : g_rev
        assign cfg_lane[g] = cfg_idx_q[LANE_W-1-g];
    end

    bf_lane_plan #(.LANE_W(LANE_W)) u_plan (
        .width_code (width_q),
        .beat_idx   (beat_idx_q),
        .beat_size  (beat_size),
        .beats_last (beats_last),
        .lane       (word_lane)
    );

    assign ack       = rd_req && rd_ack;
    assign last_cfg  = (cfg_idx_q == '1);
    assign last_beat = (beat_idx_q == beats_last);
    assign last_word = (word_idx_q == WIDX_W'(NUM_WORDS - 1));
    assign asm_size  = (state_q == ST_WORDS) ? beat_size : SZ_BYTE;
    assign asm_lane  = (state_q == ST_WORDS) ? word_lane : cfg_lane;
    assign asm_clr   = ack && (((state_q == ST_CFG) && last_cfg) ||
                               ((state_q == ST_WORDS) && last_beat));
    assign sum_add   = ack && (state_q == ST_WORDS) && last_beat;

    bf_word_asm #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_asm (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (asm_clr),
        .load   (ack),
        .size   (asm_size),
        .lane   (asm_lane),
        .din    (rd_data),
        .acc    (asm_acc),
        .merged (asm_merged)
    );

    bf_sum_check #(.DATA_W(DATA_W)) u_sum (
        .clk      (clk),
        .rst_n    (rst_n),
        .add      (sum_add),
        .word     (asm_merged),
        .sum_zero (sum_zero)
    );

    // straps follow their pins for as long as reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_en_q <= selftest_strap;
            width_q <= width_strap;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SELFTEST: if (!st_en_q || cnt_q == CNT_W'(SELFTEST_CYCLES - 1)) state_d = ST_PULSE;
            ST_PULSE:    if (cnt_q == CNT_W'(PULSE_CYCLES - 1)) state_d = ST_CFG;
            ST_CFG:      if (ack && last_cfg) state_d = ST_WORDS;
            ST_WORDS:    if (ack && last_beat && last_word) state_d = ST_CHECK;
            ST_CHECK:    state_d = sum_zero ? ST_PASS : ST_FAIL;
            ST_PASS:     state_d = ST_PASS;
            ST_FAIL:     state_d = ST_FAIL;
            default:     state_d = ST_FAIL;
        endcase
    end

    // state register and sequencing counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_SELFTEST;
            cnt_q      <= '0;
            cfg_idx_q  <= '0;
            beat_idx_q <= '0;
            word_idx_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) cnt_q <= '0;
            else                    cnt_q <= cnt_q + 1'b1;
            if (ack && state_q == ST_CFG) cfg_idx_q <= cfg_idx_q + 1'b1;
            if (ack && state_q == ST_WORDS) begin
                if (last_beat) begin
                    beat_idx_q <= '0;
                    word_idx_q <= word_idx_q + 1'b1;
                end else begin
                    beat_idx_q <= beat_idx_q + 1'b1;
                end
            end
        end
    end

    // captured results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            ip_q   <= '0;
            ctrl_q <= '0;
        end else begin
            if (ack && state_q == ST_CFG && last_cfg) cfg_q <= asm_merged;
            if (sum_add && word_idx_q == WIDX_W'(0)) ip_q   <= asm_merged;
            if (sum_add && word_idx_q == WIDX_W'(1)) ctrl_q <= asm_merged;
        end
    end

    // outputs decoded from the state
    always_comb begin
        rd_req         = 1'b0;
        rd_addr        = BASE_ADDR;
        rd_size        = SZ_BYTE;
        rd_burst       = 1'b0;
        fail_n         = 1'b0;
        region_cfg_vld = 1'b0;
        boot_ok        = 1'b0;
        boot_err       = 1'b0;
        unique case (state_q)
            ST_SELFTEST: rd_addr = BASE_ADDR + ADDR_W'(cnt_q);
            ST_PULSE:    fail_n  = 1'b1;
            ST_CFG: begin
                rd_req  = 1'b1;
                rd_addr = BASE_ADDR + ADDR_W'(cfg_lane) * ADDR_W'(CFG_BYTES);
            end
            ST_WORDS: begin
                rd_req         = 1'b1;
                rd_size        = beat_size;
                rd_burst       = !last_beat;
                rd_addr        = BASE_ADDR + ADDR_W'(CFG_SPAN)
                               + ADDR_W'(word_idx_q) * ADDR_W'(CFG_BYTES) + ADDR_W'(word_lane);
                region_cfg_vld = 1'b1;
            end
            ST_CHECK: region_cfg_vld = 1'b1;
            ST_PASS: begin
                region_cfg_vld = 1'b1;
                fail_n         = 1'b1;
                boot_ok        = 1'b1;
            end
            ST_FAIL: begin
                region_cfg_vld = 1'b1;
                boot_err       = 1'b1;
            end
            default: ;
        endcase
    end

    assign region_cfg = cfg_q;
    assign start_ip   = ip_q;
    assign ctrl_ptr   = ctrl_q;

    // R8: a pending request keeps its address and size until acknowledged
    p_hold_until_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr) && $stable(rd_size) && $stable(rd_burst)));

    // R5: every address stays inside the boot record window
    p_in_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> ((rd_addr - BASE_ADDR) < ADDR_W'(WIN_BYTES)));

    // R4: configuration beats are single, unburst bytes
    p_cfg_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !region_cfg_vld) |-> (rd_size == SZ_BYTE && !rd_burst));

    // R3: the fail pin is never high while a read is in flight
    p_fail_low_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> !fail_n);

    // R10: pass is sticky and either outcome silences the bus
    p_pass_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        boot_ok |=> (boot_ok && fail_n && !rd_req));
    p_quiet_after_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_ok || boot_err) |-> !rd_req);

endmodule

// File: tb/boot_rec_fetch_tb.sv
`timescale 1ns/1ps
module boot_rec_fetch_tb;

    localparam logic [31:0] BASE = 32'hFEFF_FF30;
    localparam int ST_CYC = 16;
    localparam int PL_CYC = 2;

    typedef struct packed {
        logic [31:0] a;
        logic [1:0]  s;
        logic        b;
    } req_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        selftest_strap = 1'b0;
    logic [1:0]  width_strap = 2'b00;
    logic        rd_req, rd_burst, rd_ack = 1'b0;
    logic [31:0] rd_addr, rd_data = '0;
    logic [1:0]  rd_size;
    logic        fail_n, region_cfg_vld, boot_ok, boot_err;
    logic [31:0] region_cfg, start_ip, ctrl_ptr;

    int   n_chk = 0, n_fail = 0, cycles = 0, resp_delay = 0, wait_cnt = 0;
    req_t exp_q[$];
    logic [31:0] cfg_img;
    logic [31:0] img [8];

    always #10 clk = ~clk;

    boot_rec_fetch u_dut (
        .clk(clk), .rst_n(rst_n), .selftest_strap(selftest_strap), .width_strap(width_strap),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_size(rd_size), .rd_burst(rd_burst),
        .rd_ack(rd_ack), .rd_data(rd_data), .fail_n(fail_n), .region_cfg(region_cfg),
        .region_cfg_vld(region_cfg_vld), .start_ip(start_ip), .ctrl_ptr(ctrl_ptr),
        .boot_ok(boot_ok), .boot_err(boot_err)
    );

    task automatic check(input bit ok, input string req, input string detail);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", req, detail);
        end
    endtask

    function automatic logic [31:0] mem_rd(input logic [31:0] a, input logic [1:0] s);
        logic [31:0] off = a - BASE;
        logic [31:0] w;
        if (off < 16) return {24'hDEAD5A, cfg_img[8*(off>>2) +: 8]};
        w = img[(off - 16) >> 2] >> (8 * off[1:0]);
        case (s)
            2'b00:   return {24'hA5A5A5, w[7:0]};
            2'b01:   return {16'hC3C3, w[15:0]};
            default: return w;
        endcase
    endfunction

    // driver: expected bus beats for one boot
    task automatic push_expect(input logic [1:0] wcode);
        int bw;
        logic [1:0] sz;
        exp_q.delete();
        for (int k = 0; k < 4; k++) begin
            int ln = {k[0], k[1]};
            exp_q.push_back('{a: BASE + 32'(4 * ln), s: 2'b00, b: 1'b0});
        end
        bw = (wcode == 2'b00) ? 1 : (wcode == 2'b01) ? 2 : 4;
        sz = (wcode == 2'b00) ? 2'b00 : (wcode == 2'b01) ? 2'b01 : 2'b10;
        for (int i = 0; i < 8; i++)
            for (int b = 0; b < 4 / bw; b++)
                exp_q.push_back('{a: BASE + 32'(16 + 4 * i + b * bw), s: sz, b: (b != 4 / bw - 1)});
    endtask

    // monitor and memory responder: pops one expected beat per acknowledge
    always @(negedge clk) begin
        cycles++;
        if (!rst_n) begin
            rd_ack = 1'b0;
            wait_cnt = 0;
        end else if (rd_ack) begin
            rd_ack = 1'b0;
        end else if (rd_req) begin
            if (wait_cnt >= resp_delay) begin
                req_t e;
                wait_cnt = 0;
                rd_ack = 1'b1;
                rd_data = mem_rd(rd_addr, rd_size);
                check(fail_n == 1'b0, "R3", $sformatf("fail_n during read act=%b exp=0", fail_n));
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5", $sformatf("extra read act=%h exp=none", rd_addr));
                end else begin
                    e = exp_q.pop_front();
                    check(rd_addr == e.a && rd_size == e.s, "R4/R5",
                          $sformatf("beat act=%h/%0d exp=%h/%0d", rd_addr, rd_size, e.a, e.s));
                    check(rd_burst == e.b, "R7",
                          $sformatf("burst at %h act=%b exp=%b", rd_addr, rd_burst, e.b));
                end
            end else begin
                wait_cnt++;
            end
        end
    end

    task automatic run_case(input bit st, input logic [1:0] wcode, input int dly,
                            input bit good, input logic [31:0] seed);
        logic [31:0] acc = '0;
        int lo = 0, hi = 0, t = 0;
        bit quiet = 1'b1;
        rst_n = 1'b0;
        selftest_strap = st;
        width_strap = wcode;
        resp_delay = dly;
        cfg_img = seed ^ 32'h1357_9BDF;
        for (int i = 0; i < 7; i++) begin
            img[i] = seed * 32'(i + 3) + 32'h0101_0F0F * 32'(i);
            acc += img[i];
        end
        img[7] = good ? (32'h0 - acc) : (32'h1 - acc);
        push_expect(wcode);
        repeat (3) @(negedge clk);
        #1;
        check(!rd_req && !fail_n && !boot_ok && !boot_err, "R3",
              $sformatf("reset state act=%b%b%b%b exp=0000", rd_req, fail_n, boot_ok, boot_err));
        @(negedge clk);
        rst_n = 1'b1;
        width_strap = ~wcode;          // R1: changes after release are ignored
        selftest_strap = ~st;
        #1;
        while (!fail_n && lo < 1000) begin
            if (rd_req) quiet = 1'b0;
            lo++;
            @(negedge clk); #1;
        end
        while (fail_n && hi < 1000) begin
            if (rd_req) quiet = 1'b0;
            hi++;
            @(negedge clk); #1;
        end
        check(lo == (st ? ST_CYC : 1), "R2", $sformatf("self-test cycles act=%0d exp=%0d", lo, st ? ST_CYC : 1));
        check(quiet, "R2", $sformatf("strobe before fetch act=%b exp=0", !quiet));
        check(hi == PL_CYC, "R3", $sformatf("pulse length act=%0d exp=%0d", hi, PL_CYC));
        while (!(boot_ok || boot_err) && t < 5000) begin
            t++;
            @(negedge clk); #1;
        end
        check(boot_ok == good && boot_err == !good, "R10",
              $sformatf("outcome ok/err act=%b%b exp=%b%b", boot_ok, boot_err, good, !good));
        check(fail_n == good, "R10", $sformatf("fail_n act=%b exp=%b", fail_n, good));
        check(region_cfg_vld && region_cfg == cfg_img, "R4",
              $sformatf("cfg act=%h exp=%h", region_cfg, cfg_img));
        check(start_ip == img[0], "R9", $sformatf("ip act=%h exp=%h", start_ip, img[0]));
        check(ctrl_ptr == img[1], "R6", $sformatf("ctrl act=%h exp=%h", ctrl_ptr, img[1]));
        check(exp_q.size() == 0, "R5", $sformatf("beats left act=%0d exp=0", exp_q.size()));
        quiet = 1'b1;
        repeat (10) begin
            @(negedge clk); #1;
            if (rd_req) quiet = 1'b0;
        end
        check(quiet && (boot_ok == good), "R10", $sformatf("post-outcome req act=%b exp=0", !quiet));
    endtask

    initial begin
        run_case(1'b1, 2'b10, 1, 1'b1, 32'h2468_ACE1);  // R5 32-bit, self-test
        run_case(1'b0, 2'b01, 0, 1'b1, 32'h0BAD_F00D);  // R5 16-bit, no self-test
        run_case(1'b1, 2'b00, 2, 1'b0, 32'h7777_1234);  // R6 8-bit, bad sum
        run_case(1'b0, 2'b00, 0, 1'b1, 32'hC001_D00D);  // R6 8-bit, good sum
        run_case(1'b0, 2'b11, 1, 1'b1, 32'h5555_AAAA);  // R1 code 11 acts as 32-bit
        run_case(1'b0, 2'b01, 2, 1'b0, 32'h1111_2222);  // R8 16-bit, slow memory, bad sum
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    always @(posedge clk) begin
        if (cycles > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run hung act=%0d exp<150000 cycles", cycles);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule